// File: doc/BRIEF.md
# Regulator Command Sequencer

This block plays a programmed list of command bytes out to an external power-management regulator. Software fills a 32-entry command file through a plain write port. Each entry holds one byte and four control flags. A start pulse names the entry to begin from. The sequencer then walks the file and hands each byte to a byte-transmit port with a valid/ready handshake. In a full system, a serial bus master sits behind that port.

Each entry can ask for four things. It can ask for a wait before it goes out, with the length taken from a shared delay setting. It can chain the following entry into the same transfer. It can hold itself back until the processor clocks have stopped. It can mark the end of the sequence. The walk wraps from the top entry back to entry 0. The pointer comes to rest on the entry that ended the sequence. A busy flag covers the whole run, and a single-cycle done pulse marks its end.

The controller has six states:

- IDLE: waiting for a start pulse.
- FETCH: examines the current entry.
- HOLD: waits for the clock-stopped indication.
- DELAY: counts the programmed wait.
- SEND: presents the byte.
- GAP: one spacing cycle after a transfer ends.

The transitions are:

- IDLE to FETCH on start.
- FETCH to HOLD when the entry is static and the clocks are running.
- FETCH to DELAY when the entry is delayed and the delay setting is non-zero.
- FETCH to SEND otherwise.
- HOLD to FETCH once the clocks have stopped.
- DELAY to SEND when the count expires.
- SEND to IDLE when an end-flagged byte is accepted.
- SEND to SEND when a chained byte is accepted.
- SEND to GAP when any other byte is accepted.
- GAP to FETCH.

Top module: `regcmd_seq`

## Requirements
- R1: After reset, busy, done and tx_valid are low and cur_ptr is 0.
- R2: A start pulse while idle loads cur_ptr from start_ptr. Bytes then go out in ascending entry order from that entry, and tx_valid is only ever high while busy is high. The entry write word is laid out as follows: bits [7:0] hold the byte, bit 8 is the end flag, bit 9 is the delay flag, bit 10 is the chain flag and bit 11 is the static flag.
- R3: The pointer moves to the next entry only when a byte is accepted and that entry's end flag is clear. After a sequence, cur_ptr holds the index of the end-flagged entry.
- R4: After entry 31 is accepted with its end flag clear, the walk continues at entry 0.
- R5: A sequence ends when an end-flagged byte is accepted. In the next cycle busy is low and done is high, and done is high for exactly one cycle.
- R6: A byte is accepted only in a cycle where tx_valid and tx_ready are both high. While tx_valid is high and tx_ready is low, tx_data and tx_valid hold steady.
- R7: An entry reached through FETCH with its delay flag set waits delay_cfg cycles in addition to the normal fetch latency. The first byte appears 1 + delay_cfg cycles after the start edge, and a delay_cfg of 0 adds no wait.
- R8: After a chained byte without the end flag is accepted, the next entry's byte is presented in the very next cycle. The delay and static flags of that next entry are ignored. tx_end is low for such a byte and high for any byte that is unchained or end-flagged.
- R9: After a byte with tx_end high is accepted and the sequence continues, tx_valid is low for two cycles before the next byte, when that byte has neither a wait nor a hold.
- R10: An entry with the static flag that is reached through FETCH is not presented while clocks_stopped is low. It goes out once clocks_stopped is high.
- R11: A start pulse while busy has no effect: cur_ptr and the byte stream are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command file write strobe |
| wr_addr | input | 5 | Entry index to write |
| wr_data | input | 12 | Entry word: byte [7:0], end [8], delay [9], chain [10], static [11] |
| start | input | 1 | Start pulse, honoured only while idle |
| start_ptr | input | 5 | First entry of the sequence |
| delay_cfg | input | 8 | Wait length in cycles for delay-flagged entries |
| clocks_stopped | input | 1 | High once the processor clocks are stopped |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Offered byte |
| tx_end | output | 1 | Offered byte closes the current transfer |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse after the final byte is accepted |
| cur_ptr | output | 5 | Current entry index |

## Verification
The bench wraps a sequence from entry 31 to entry 0. A design that saturated there, or reset to the start entry, would send the wrong bytes or stop with the wrong cur_ptr.

It chains bytes through entries whose delay and static flags are set. A design that re-examined chained entries would leave a hole in the transfer, or would hang waiting for the clocks to stop.

It measures the first-byte latency with zero and non-zero delay settings, and the gap after a closed transfer. A counter that is off by one shows up directly as a shifted cycle.

It pulses start in the middle of a long wait, and it holds back a static entry while the clocks run. A design that restarted on the extra start, or let the static byte through, would produce a different byte stream or pointer.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_HOLD,
        S_DELAY,
        S_SEND,
        S_GAP
    } seq_state_e;

    typedef struct packed {
        logic stat;
        logic chain;
        logic dly;
        logic fin;
    } cmd_flags_t;

    localparam int FLAG_W = $bits(cmd_flags_t);

endpackage

// File: rtl/regseq_cmd_file.sv
module regseq_cmd_file
    import regseq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_byte,
    input  cmd_flags_t        wr_flags,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_byte,
    output cmd_flags_t        rd_flags
);

    logic [DATA_W-1:0] byte_q  [DEPTH];
    cmd_flags_t        flags_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q[i]  <= '0;
                flags_q[i] <= '0;
            end else if (wr_en && (wr_addr == PTR_W'(i))) begin
                byte_q[i]  <= wr_byte;
                flags_q[i] <= wr_flags;
            end
        end
    end

    assign rd_byte  = byte_q[rd_addr];
    assign rd_flags = flags_q[rd_addr];

endmodule

// File: rtl/regseq_delay_timer.sv
module regseq_delay_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             final_tick
);

    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign final_tick = (cnt_q == DLY_W'(1));

endmodule

// File: rtl/regseq_fsm.sv
module regseq_fsm
    import regseq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    parameter int DLY_W  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PTR_W-1:0]  start_ptr,
    input  logic [DLY_W-1:0]  delay_cfg,
    input  logic              clocks_stopped,
    input  logic [DATA_W-1:0] ent_byte,
    input  cmd_flags_t        ent_flags,
    input  logic              tmr_final,
    input  logic              tx_ready,
    output logic [PTR_W-1:0]  ptr,
    output logic              tmr_load,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_end,
    output logic              busy,
    output logic              done
);

    localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH - 1);

    seq_state_e state_q, state_d;
    logic       accept;
    logic       must_hold;
    logic       want_wait;
    logic       done_q;

    assign accept    = (state_q == S_SEND) && tx_ready;
    assign must_hold = ent_flags.stat && !clocks_stopped;
    assign want_wait = ent_flags.dly && (delay_cfg != '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_FETCH;
            S_FETCH: begin
                if (must_hold)      state_d = S_HOLD;
                else if (want_wait) state_d = S_DELAY;
                else                state_d = S_SEND;
            end
            S_HOLD:  if (clocks_stopped) state_d = S_FETCH;
            S_DELAY: if (tmr_final) state_d = S_SEND;
            S_SEND: begin
                if (tx_ready) begin
                    if (ent_flags.fin)        state_d = S_IDLE;
                    else if (ent_flags.chain) state_d = S_SEND;
                    else                      state_d = S_GAP;
                end
            end
            S_GAP:   state_d = S_FETCH;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (state_q == S_IDLE && start) begin
            ptr <= start_ptr;
        end else if (accept && !ent_flags.fin) begin
            ptr <= (ptr == TOP_IDX) ? '0 : ptr + PTR_W'(1);
        end
    end

    // completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= accept && ent_flags.fin;
    end

    // outputs
    always_comb begin
        tx_valid = (state_q == S_SEND);
        tx_data  = ent_byte;
        tx_end   = !ent_flags.chain || ent_flags.fin;
        busy     = (state_q != S_IDLE);
        tmr_load = (state_q == S_FETCH) && !must_hold && want_wait;
        done     = done_q;
    end

endmodule

// File: rtl/regcmd_seq.sv
module regcmd_seq
    import regseq_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    parameter int DLY_W  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int WORD_W = DATA_W + FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic [PTR_W-1:0]  start_ptr,
    input  logic [DLY_W-1:0]  delay_cfg,
    input  logic              clocks_stopped,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_end,
    input  logic              tx_ready,
    output logic              busy,
    output logic              done,
    output logic [PTR_W-1:0]  cur_ptr
);

    logic [DATA_W-1:0] ent_byte;
    cmd_flags_t        ent_flags;
    logic              tmr_load;
    logic              tmr_final;

    regseq_cmd_file #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_byte  (wr_data[DATA_W-1:0]),
        .wr_flags (cmd_flags_t'(wr_data[WORD_W-1:DATA_W])),
        .rd_addr  (cur_ptr),
        .rd_byte  (ent_byte),
        .rd_flags (ent_flags)
    );

    regseq_delay_timer #(.DLY_W(DLY_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .load_val   (delay_cfg),
        .final_tick (tmr_final)
    );

    regseq_fsm #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DLY_W(DLY_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .start_ptr      (start_ptr),
        .delay_cfg      (delay_cfg),
        .clocks_stopped (clocks_stopped),
        .ent_byte       (ent_byte),
        .ent_flags      (ent_flags),
        .tmr_final      (tmr_final),
        .tx_ready       (tx_ready),
        .ptr            (cur_ptr),
        .tmr_load       (tmr_load),
        .tx_valid       (tx_valid),
        .tx_data        (tx_data),
        .tx_end         (tx_end),
        .busy           (busy),
        .done           (done)
    );

endmodule

// File: rtl/regcmd_seq_chk.sv
module regcmd_seq_chk #(
    parameter int PTR_W  = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_end,
    input logic [DATA_W-1:0] tx_data,
    input logic              busy,
    input logic              done,
    input logic [PTR_W-1:0]  cur_ptr
);

    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy); // R2

    AST_PTR_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> $stable(cur_ptr)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy)); // R5

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R6

    AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_end) |=> tx_valid); // R8

    AST_GAP_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_end) |=> !tx_valid); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(tx_valid && tx_ready)) |=> (busy && $stable(cur_ptr))); // R11

endmodule

bind regcmd_seq regcmd_seq_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_end   (tx_end),
    .tx_data  (tx_data),
    .busy     (busy),
    .done     (done),
    .cur_ptr  (cur_ptr)
);

// File: tb/tb_regcmd_seq.sv
module tb_regcmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        start = 1'b0;
    logic [4:0]  start_ptr = '0;
    logic [7:0]  delay_cfg = '0;
    logic        clocks_stopped = 1'b1;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_end;
    logic        tx_ready = 1'b1;
    logic        busy;
    logic        done;
    logic [4:0]  cur_ptr;

    regcmd_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .start(start), .start_ptr(start_ptr),
        .delay_cfg(delay_cfg), .clocks_stopped(clocks_stopped),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_end(tx_end),
        .tx_ready(tx_ready), .busy(busy), .done(done), .cur_ptr(cur_ptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rdy_mode = 0;   // 0 always ready, 1 random, 2 never

    logic [7:0] m_byte [N];
    logic       m_fin [N], m_dly [N], m_chain [N], m_stat [N];

    logic [7:0] exp_b [128];
    logic       exp_e [128];
    int         exp_n;
    int         exp_ptr;

    logic [7:0] got_b [128];
    logic       got_e [128];
    int         got_c [128];
    int         got_n;
    int         first_cyc;
    int         done_cnt;
    logic       mon_on = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish (actual cycles=%0d expected<150000)", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rdy_mode == 0)      tx_ready = 1'b1;
        else if (rdy_mode == 2) tx_ready = 1'b0;
        else                    tx_ready = ($urandom_range(0, 9) < 7);
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if (tx_valid && first_cyc < 0) first_cyc = cyc;
            if (tx_valid && tx_ready && got_n < 128) begin
                got_b[got_n] = tx_data;
                got_e[got_n] = tx_end;
                got_c[got_n] = cyc;
                got_n = got_n + 1;
            end
            if (done) done_cnt = done_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] b, input logic fin,
                      input logic dly, input logic chain, input logic st);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 5'(a);
        wr_data = {st, chain, dly, fin, b};
        m_byte[a] = b; m_fin[a] = fin; m_dly[a] = dly; m_chain[a] = chain; m_stat[a] = st;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // expected stream from the requirements
    task automatic compute_exp(input int p);
        int prev_chain;
        exp_n = 0;
        for (int k = 0; k < 64; k++) begin
            exp_b[exp_n] = m_byte[p];
            exp_e[exp_n] = !m_chain[p] || m_fin[p];
            exp_n = exp_n + 1;
            if (m_fin[p]) break;
            p = (p == N - 1) ? 0 : p + 1;
        end
        exp_ptr = p;
    endtask

    task automatic launch(input int p);
        got_n = 0; first_cyc = -1; done_cnt = 0; mon_on = 1'b1;
        @(negedge clk);
        start = 1'b1;
        start_ptr = 5'(p);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run(input string req, output int c0_unused);
        int lim;
        lim = 0;
        c0_unused = 0;
        while (done_cnt == 0 && lim < 5000) begin
            @(posedge clk);
            lim++;
        end
        repeat (3) @(posedge clk);
        chk("R5", "done pulse count", done_cnt, 1);
        chk("R5", "busy after done", int'(busy), 0);
        chk(req, "byte count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(req, "byte value", int'(got_b[i]), int'(exp_b[i]));
            chk("R8", "end marker", int'(got_e[i]), int'(exp_e[i]));
        end
        chk("R3", "resting pointer", int'(cur_ptr), exp_ptr);
        mon_on = 1'b0;
    endtask

    initial begin
        int c0;
        int dummy;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < N; i++) begin
            m_byte[i] = '0; m_fin[i] = 0; m_dly[i] = 0; m_chain[i] = 0; m_stat[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "tx_valid after reset", int'(tx_valid), 0);
        chk("R1", "cur_ptr after reset", int'(cur_ptr), 0);

        // R4: wrap 30 -> 31 -> 0
        wr(30, 8'hA1, 0, 0, 0, 0);
        wr(31, 8'hA2, 0, 0, 0, 0);
        wr(0,  8'hA3, 1, 0, 0, 0);
        compute_exp(30);
        launch(30);
        finish_run("R4", dummy);

        // R7: delay latency, non-zero and zero
        wr(7, 8'h5C, 1, 1, 0, 0);
        delay_cfg = 8'd5;
        compute_exp(7);
        launch(7);
        c0 = cyc;
        finish_run("R7", dummy);
        chk("R7", "first byte latency with delay 5", first_cyc - (c0 - 0), 6 - 0);
        delay_cfg = 8'd0;
        launch(7);
        c0 = cyc;
        finish_run("R7", dummy);
        chk("R7", "first byte latency with delay 0", first_cyc - c0, 1);

        // R8: chained bytes back to back, flags of chained entry ignored
        clocks_stopped = 1'b0;
        delay_cfg = 8'd9;
        wr(4, 8'h11, 0, 0, 1, 0);
        wr(5, 8'h22, 0, 1, 1, 1);
        wr(6, 8'h33, 1, 1, 0, 1);
        compute_exp(4);
        launch(4);
        finish_run("R8", dummy);
        if (got_n == 3) begin
            chk("R8", "chain spacing 1", got_c[1] - got_c[0], 1);
            chk("R8", "chain spacing 2", got_c[2] - got_c[1], 1);
        end
        clocks_stopped = 1'b1;

        // R9: gap after a closed transfer
        wr(10, 8'h44, 0, 0, 0, 0);
        wr(11, 8'h55, 1, 0, 0, 0);
        compute_exp(10);
        launch(10);
        finish_run("R9", dummy);
        if (got_n == 2) chk("R9", "spacing after end byte", got_c[1] - got_c[0], 3);

        // R10: static entry held while clocks run
        clocks_stopped = 1'b0;
        wr(15, 8'h66, 1, 0, 0, 1);
        compute_exp(15);
        launch(15);
        repeat (20) @(posedge clk);
        chk("R10", "bytes sent while clocks run", got_n, 0);
        chk("R10", "busy while held", int'(busy), 1);
        clocks_stopped = 1'b1;
        finish_run("R10", dummy);

        // R11 and R6: start ignored during a long wait, ready stalls
        delay_cfg = 8'd40;
        wr(20, 8'h77, 0, 1, 0, 0);
        wr(21, 8'h88, 1, 0, 0, 0);
        wr(3,  8'h99, 1, 0, 0, 0);
        compute_exp(20);
        launch(20);
        repeat (5) @(negedge clk);
        start = 1'b1; start_ptr = 5'd3;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R11", "pointer after ignored start", int'(cur_ptr), 20);
        rdy_mode = 2;
        repeat (50) @(posedge clk);
        chk("R6", "no acceptance without ready", got_n, 0);
        rdy_mode = 0;
        finish_run("R11", dummy);

        // R2/R3: random command files and start points
        delay_cfg = 8'd0;
        for (int t = 0; t < 12; t++) begin
            int sp;
            rdy_mode = 1;
            delay_cfg = 8'($urandom_range(0, 6));
            sp = $urandom_range(0, N - 1);
            for (int i = 0; i < N; i++)
                wr(i, 8'($urandom), ($urandom_range(0, 5) == 0),
                   ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
                   ($urandom_range(0, 3) == 0));
            begin
                int fi;
                fi = (sp + $urandom_range(0, N - 1)) % N;
                wr(fi, m_byte[fi], 1'b1, m_dly[fi], m_chain[fi], m_stat[fi]);
            end
            compute_exp(sp);
            launch(sp);
            finish_run("R2", dummy);
        end
        rdy_mode = 0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule